// File: doc/BRIEF.md
# Interprocessor Interrupt Issue and Error Logging Unit

This unit sits between a core's register bus and the interrupt fabric. It accepts writes to three targets: a 64-bit interrupt command word, a vector-only self-interrupt register, and an error status register. Each accepted command or self-interrupt write is decoded, checked and, if it passes, held as one outgoing interrupt message on a valid/ready issue port. Vector and delivery-mode violations are not issued. Instead they set sticky bits in the error status register.

The same register also records illegal vectors seen on the receive side. Software clears it by writing zero, and only zero is accepted. An error interrupt request is raised while any logged error is present and the mask input is low. The fabric, priority arbitration and the request and in-service arrays live outside this block.

Back-pressure works as follows. The issue port presents one message at a time. The message and all of its fields stay unchanged until `iss_ready` is seen high at a clock edge. The write port shares a single ready signal, `wr_ready`, for all targets. It is high whenever the issue slot is empty or is being drained in the same cycle, so a consumer that is always ready allows one accepted write every cycle.

Top module: `ipi_issue_unit`

## Requirements
- R1: A write accepted with `wr_sel`=00 whose mode is legal and whose vector is legal is presented on the issue port at the next clock edge. The fields are taken from the word as follows: destination from bits 63:32, vector from 7:0, delivery mode from 10:8, destination mode from bit 11 (1 logical), level from bit 14, trigger from bit 15 (1 level), and shorthand from 19:18 (00 none, 01 self, 10 all including self, 11 all excluding self).
- R2: A write accepted with `wr_sel`=01 issues a message with the vector from bits 7:0, shorthand 01, delivery mode 000, edge trigger, level 0, physical destination mode and destination 0. It leaves the stored command word unchanged.
- R3: While `iss_valid` is high and `iss_ready` is low, the message stays valid and stable. `wr_ready` equals `!iss_valid || iss_ready`, so back-to-back writes issue on consecutive cycles when the consumer is ready.
- R4: A command or self interrupt with delivery mode 000 and a vector below 16 is not issued and sets error bit 5.
- R5: Delivery mode 001 is not issued and sets error bit 4. Modes 011 and 111 are not issued and log nothing. Modes 000, 010, 100, 101 and 110 are issued.
- R6: When `rx_valid` is high, `rx_deliver` is high in the same cycle if and only if `rx_vector` is 16 or more. A vector below 16 sets error bit 6 at the next edge, and nothing else.
- R7: An accepted error-register write (`wr_sel`=10) of zero clears all logged bits. A bit set in that same cycle stays set. A non-zero write raises `wr_fault` during the accepting cycle and leaves the register unchanged.
- R8: Error bits 4, 5 and 6 are sticky until cleared. All other bits, including bit 7, always read zero. A read with `rd_sel`=10 returns the register zero-extended.
- R9: Errors are logged whatever the value of `err_mask`. `err_irq` is high exactly when some logged bit is set and `err_mask` is low.
- R10: A read with `rd_sel`=00 returns the last word accepted with `wr_sel`=00, with bit 12 forced to zero. The value is 0 after reset.
- R11: A read with `rd_sel`=01 while `rd_en` is high raises `rd_fault` and returns 0. `rd_sel`=11 returns 0 with no fault.
- R12: `iss_broadcast` is high for an issued command whose shorthand is 00 and whose destination is FFFF_FFFFH, in either destination mode. It is low otherwise.
- R13: After reset, `iss_valid` and `err_irq` are low, `wr_ready` is high, and the error register and stored command read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted at this edge when high with wr_valid |
| wr_sel | input | 2 | Write target: 00 command, 01 self, 10 error register, 11 none |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Rejected non-zero error-register write, this cycle |
| rd_en | input | 1 | Read strobe, used to qualify rd_fault |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 64 | Read data (combinational) |
| rd_fault | output | 1 | Read of the write-only self register |
| rx_valid | input | 1 | Incoming interrupt present |
| rx_vector | input | 8 | Incoming interrupt vector |
| rx_deliver | output | 1 | Incoming interrupt passed on to the core |
| err_mask | input | 1 | Error-interrupt mask |
| err_irq | output | 1 | Error-interrupt request |
| iss_valid | output | 1 | Issue message valid |
| iss_ready | input | 1 | Fabric accepts the issue message |
| iss_dest | output | 32 | Destination |
| iss_mode | output | 3 | Delivery mode |
| iss_dest_logical | output | 1 | Destination mode, 1 logical |
| iss_level | output | 1 | Level bit |
| iss_trigger | output | 1 | Trigger, 1 level |
| iss_shorthand | output | 2 | Destination shorthand |
| iss_vector | output | 8 | Vector |
| iss_broadcast | output | 1 | Destination is the all-ones broadcast |

## Verification
The assertions assume that `iss_ready` is a plain input that the fabric may hold low for any number of cycles. They also assume that error-register writes and receive-side errors may land in the same cycle. The bench exercises both cases on purpose: it holds `iss_ready` low across a pending write, and it drives a zero clear-write together with an illegal received vector. Elsewhere the bench keeps `iss_ready` high and drives writes only at falling edges, so every write is accepted at the next edge. The bench sweeps all 256 self vectors and all 256 received vectors, and every delivery mode against a legal and an illegal vector.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned CMD_W  = 64;
  localparam int unsigned DEST_W = 32;
  localparam int unsigned VEC_W  = 8;

  localparam int unsigned ERRB_REDIR    = 4;
  localparam int unsigned ERRB_SEND_VEC = 5;
  localparam int unsigned ERRB_RECV_VEC = 6;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'b00,
    SEL_SELF = 2'b01,
    SEL_ERR  = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSV7   = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE     = 2'b00,
    SH_SELF     = 2'b01,
    SH_ALL_INCL = 2'b10,
    SH_ALL_EXCL = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    dmode_e            mode;
    logic              dest_logical;
    logic              level;
    logic              trig_level;
    shorthand_e        shorthand;
    logic [VEC_W-1:0]  vector;
    logic              broadcast;
  } ipi_msg_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_pkg::*;
#(
  parameter int unsigned MIN_VEC = 16
) (
  input  logic             is_self,
  input  logic [CMD_W-1:0] word,
  output ipi_msg_t         msg,
  output logic             issue_ok,
  output logic             err_redir,
  output logic             err_vec
);
  localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VEC);

  logic mode_ok;
  logic unused_bits;
  assign unused_bits = ^{word[31:20], word[17:16], word[13:12]};

  always_comb begin
    msg = '0;
    msg.vector = word[VEC_W-1:0];
    if (is_self) begin
      msg.mode      = DM_FIXED;
      msg.shorthand = SH_SELF;
    end else begin
      msg.dest         = word[CMD_W-1:CMD_W-DEST_W];
      msg.mode         = dmode_e'(word[10:8]);
      msg.dest_logical = word[11];
      msg.level        = word[14];
      msg.trig_level   = word[15];
      msg.shorthand    = shorthand_e'(word[19:18]);
      msg.broadcast    = (word[19:18] == 2'b00) && (&word[CMD_W-1:CMD_W-DEST_W]);
    end
  end

  always_comb begin
    case (msg.mode)
      DM_FIXED, DM_SMI, DM_NMI, DM_INIT, DM_START: mode_ok = 1'b1;
      default:                                     mode_ok = 1'b0;
    endcase
  end

  assign err_redir = (msg.mode == DM_LOWPRI);
  assign err_vec   = (msg.mode == DM_FIXED) && (msg.vector < MIN_V);
  assign issue_ok  = mode_ok && !err_vec;
endmodule

// File: rtl/ipi_issue_slot.sv
module ipi_issue_slot
  import ipi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  ipi_msg_t msg_in,
  input  logic     out_ready,
  output logic     out_valid,
  output ipi_msg_t msg_out
);
  logic     valid_q;
  ipi_msg_t msg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        msg_q   <= msg_in;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign msg_out   = msg_q;

  // R3: a pending message is held unchanged under back-pressure
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(msg_out)));

  // R3: a load never overwrites a message that is not leaving
  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));
endmodule

// File: rtl/ipi_err_status.sv
module ipi_err_status
  import ipi_pkg::*;
#(
  parameter int unsigned ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] err_o
);
  localparam logic [ERR_W-1:0] IMPL =
    ERR_W'((1 << ERRB_REDIR) | (1 << ERRB_SEND_VEC) | (1 << ERRB_RECV_VEC));

  logic unused_set;
  assign unused_set = |(set_i & ~IMPL);

  for (genvar b = 0; b < ERR_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= (bit_q & ~clr_i) | set_i[b];
      end
      assign err_o[b] = bit_q;

      // R8: a logged bit stays until cleared
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o[b] && !clr_i) |=> err_o[b]);

      // R7: a new error wins over a clear in the same cycle
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> err_o[b]);
    end else begin : g_zero
      assign err_o[b] = 1'b0;
    end
  end

  // R7: a clear with nothing new leaves the register empty
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|set_i)) |=> (err_o == '0));
endmodule

// File: rtl/ipi_issue_unit.sv
module ipi_issue_unit
  import ipi_pkg::*;
#(
  parameter int unsigned MIN_VEC = 16,
  parameter int unsigned ERR_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [1:0]  wr_sel,
  input  logic [63:0] wr_data,
  output logic        wr_fault,
  input  logic        rd_en,
  input  logic [1:0]  rd_sel,
  output logic [63:0] rd_data,
  output logic        rd_fault,
  input  logic        rx_valid,
  input  logic [7:0]  rx_vector,
  output logic        rx_deliver,
  input  logic        err_mask,
  output logic        err_irq,
  output logic        iss_valid,
  input  logic        iss_ready,
  output logic [31:0] iss_dest,
  output logic [2:0]  iss_mode,
  output logic        iss_dest_logical,
  output logic        iss_level,
  output logic        iss_trigger,
  output logic [1:0]  iss_shorthand,
  output logic [7:0]  iss_vector,
  output logic        iss_broadcast
);
  localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VEC);
  localparam int unsigned      PAD_W = CMD_W - ERR_W;
  localparam logic [CMD_W-1:0] RD_MASK = ~(CMD_W'(1) << 12);

  logic acc, acc_cmd, acc_self, acc_err, acc_issue_path;
  logic slot_valid;
  ipi_msg_t dec_msg, out_msg;
  logic dec_ok, dec_redir, dec_vec;
  logic rx_bad;
  logic [ERR_W-1:0] err_set, err_q;
  logic err_clr;
  logic [CMD_W-1:0] cmd_q;

  assign wr_ready       = !slot_valid || iss_ready;
  assign acc            = wr_valid && wr_ready;
  assign acc_cmd        = acc && (wr_sel == SEL_CMD);
  assign acc_self       = acc && (wr_sel == SEL_SELF);
  assign acc_err        = acc && (wr_sel == SEL_ERR);
  assign acc_issue_path = acc_cmd || acc_self;

  ipi_cmd_decode #(.MIN_VEC(MIN_VEC)) u_dec (
    .is_self  (wr_sel == SEL_SELF),
    .word     (wr_data),
    .msg      (dec_msg),
    .issue_ok (dec_ok),
    .err_redir(dec_redir),
    .err_vec  (dec_vec)
  );

  ipi_issue_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_issue_path && dec_ok),
    .msg_in   (dec_msg),
    .out_ready(iss_ready),
    .out_valid(slot_valid),
    .msg_out  (out_msg)
  );

  assign rx_bad     = rx_valid && (rx_vector < MIN_V);
  assign rx_deliver = rx_valid && !rx_bad;

  always_comb begin
    err_set                = '0;
    err_set[ERRB_REDIR]    = acc_issue_path && dec_redir;
    err_set[ERRB_SEND_VEC] = acc_issue_path && dec_vec;
    err_set[ERRB_RECV_VEC] = rx_bad;
  end

  assign err_clr  = acc_err && (wr_data == '0);
  assign wr_fault = acc_err && (wr_data != '0);

  ipi_err_status #(.ERR_W(ERR_W)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(err_set),
    .clr_i(err_clr),
    .err_o(err_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       cmd_q <= '0;
    else if (acc_cmd) cmd_q <= wr_data & RD_MASK;
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_CMD: rd_data = cmd_q;
      SEL_ERR: rd_data = {{PAD_W{1'b0}}, err_q};
      default: rd_data = '0;
    endcase
  end
  assign rd_fault = rd_en && (rd_sel == SEL_SELF);

  assign err_irq = (|err_q) && !err_mask;

  assign iss_valid        = slot_valid;
  assign iss_dest         = out_msg.dest;
  assign iss_mode         = out_msg.mode;
  assign iss_dest_logical = out_msg.dest_logical;
  assign iss_level        = out_msg.level;
  assign iss_trigger      = out_msg.trig_level;
  assign iss_shorthand    = out_msg.shorthand;
  assign iss_vector       = out_msg.vector;
  assign iss_broadcast    = out_msg.broadcast;

  // R4: no fixed-mode message leaves with a reserved vector
  p_fixed_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_mode == 3'b000) |-> (iss_vector >= MIN_V));

  // R5: a lowest-priority command never reaches the issue port
  p_no_lowpri_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cmd && wr_data[10:8] == 3'b001) |=> !iss_valid);

  // R7: a rejected write leaves the logged errors untouched
  p_fault_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fault && !rx_bad) |=> $stable(err_q));

  // R9: an illegal received vector requests an interrupt unless masked
  p_irq_after_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bad |=> (err_irq || err_mask));
endmodule

// File: tb/tb_ipi_issue_unit.sv
module tb_ipi_issue_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_ready, wr_fault;
  logic [1:0] wr_sel = 0;
  logic [63:0] wr_data = 0;
  logic rd_en = 0, rd_fault;
  logic [1:0] rd_sel = 0;
  logic [63:0] rd_data;
  logic rx_valid = 0, rx_deliver;
  logic [7:0] rx_vector = 0;
  logic err_mask = 0, err_irq;
  logic iss_valid, iss_ready = 1;
  logic [31:0] iss_dest;
  logic [2:0] iss_mode;
  logic iss_dest_logical, iss_level, iss_trigger, iss_broadcast;
  logic [1:0] iss_shorthand;
  logic [7:0] iss_vector;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_issue_unit dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] d);
    rd_sel = s; #1; d = rd_data;
  endtask

  function automatic bit mode_legal(input int m);
    return (m == 0) || (m == 2) || (m == 4) || (m == 5) || (m == 6);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 iss_valid", iss_valid, 0);
    chk("R13 wr_ready", wr_ready, 1);
    chk("R13 err_irq", err_irq, 0);
    rd(2'b10, d); chk("R13 err reg", d, 0);
    rd(2'b00, d); chk("R13 cmd reg", d, 0);

    // R1 R4 R5 R10: every delivery mode, legal and illegal vector, all shorthands
    for (int m = 0; m < 8; m++)
      for (int vi = 0; vi < 2; vi++)
        for (int sh = 0; sh < 4; sh++) begin
          logic [7:0] v;
          logic [31:0] dst;
          logic [63:0] w;
          bit issue;
          logic [63:0] eerr;
          v = vi ? 8'(8'h40 + m) : 8'(8'h03 + m);
          dst = 32'h1234_5600 | 32'(m * 16 + vi * 4 + sh);
          w = {dst, 12'h0, 2'(sh), 2'b00, 1'(vi), 1'(m & 1), 1'b0, 1'b1, 1'(sh & 1), 3'(m), v};
          issue = mode_legal(m) && !(m == 0 && v < 16);
          eerr = ((m == 1) ? 64'h10 : 64'h0) | ((m == 0 && v < 16) ? 64'h20 : 64'h0);
          wr(2'b00, w);
          chk("R5 issue decision", iss_valid, issue);
          if (issue) begin
            chk("R1 dest", iss_dest, dst);
            chk("R1 fields", {iss_mode, iss_dest_logical, iss_level, iss_trigger, iss_shorthand, iss_vector},
                {3'(m), 1'(sh & 1), 1'(m & 1), 1'(vi), 2'(sh), v});
          end
          rd(2'b00, d); chk("R10 cmd readback", d, w & ~(64'h1 << 12));
          rd(2'b10, d); chk("R4 R5 error bits", d, eerr);
          if (eerr != 0) wr(2'b10, 64'h0);
        end

    // R2 R4: all self vectors; the command register must stay as last written
    wr(2'b00, {32'h0000_0007, 32'h0000_1450});
    for (int v = 0; v < 256; v++) begin
      wr(2'b01, 64'(v) | 64'hFFFF_FF00);
      chk("R2 self issued", iss_valid, v >= 16);
      if (v >= 16)
        chk("R2 self fields", {iss_dest, iss_mode, iss_dest_logical, iss_level, iss_trigger, iss_shorthand, iss_vector, iss_broadcast},
            {32'h0, 3'b000, 1'b0, 1'b0, 1'b0, 2'b01, 8'(v), 1'b0});
      rd(2'b10, d); chk("R4 self vector error", d, (v < 16) ? 64'h20 : 64'h0);
      if (v < 16) wr(2'b10, 64'h0);
    end
    rd(2'b00, d); chk("R2 cmd unchanged by self", d, {32'h0000_0007, 32'h0000_0450});

    // R12 broadcast
    wr(2'b00, {32'hFFFF_FFFF, 32'h0000_0830}); chk("R12 logical bcast", iss_broadcast, 1);
    wr(2'b00, {32'hFFFF_FFFF, 32'h0000_0030}); chk("R12 physical bcast", iss_broadcast, 1);
    wr(2'b00, {32'hFFFF_FFFF, 32'h0004_0030}); chk("R12 shorthand self", iss_broadcast, 0);
    wr(2'b00, {32'hFFFF_FFFE, 32'h0000_0030}); chk("R12 not all ones", iss_broadcast, 0);

    // R6 receive sweep
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); rx_valid = 1; rx_vector = 8'(v);
      #1 chk("R6 deliver", rx_deliver, v >= 16);
      @(negedge clk); rx_valid = 0;
      rd(2'b10, d); chk("R6 receive error bit", d, (v < 16) ? 64'h40 : 64'h0);
      if (v < 16) wr(2'b10, 64'h0);
    end

    // R9 mask
    err_mask = 1;
    @(negedge clk); rx_valid = 1; rx_vector = 8'd2;
    @(negedge clk); rx_valid = 0;
    rd(2'b10, d); chk("R9 logged under mask", d, 64'h40);
    chk("R9 masked irq", err_irq, 0);
    err_mask = 0; #1 chk("R9 unmasked irq", err_irq, 1);

    // R7 non-zero write rejected
    @(negedge clk); wr_valid = 1; wr_sel = 2'b10; wr_data = 64'h40;
    #1 chk("R7 fault", wr_fault, 1);
    @(negedge clk); wr_valid = 0;
    #1 chk("R7 fault drops", wr_fault, 0);
    rd(2'b10, d); chk("R7 register kept", d, 64'h40);

    // R7 R8 set wins over clear, sticky bits
    wr(2'b01, 64'h1);
    rd(2'b10, d); chk("R8 sticky both bits", d, 64'h60);
    @(negedge clk); wr_valid = 1; wr_sel = 2'b10; wr_data = 0; rx_valid = 1; rx_vector = 8'd4;
    @(negedge clk); wr_valid = 0; rx_valid = 0;
    rd(2'b10, d); chk("R7 set wins over clear", d, 64'h40);
    wr(2'b10, 64'h0);
    rd(2'b10, d); chk("R7 clear", d, 0);
    chk("R9 irq off", err_irq, 0);

    // R11 reads
    rd_en = 1; rd(2'b01, d); chk("R11 self read fault", rd_fault, 1); chk("R11 self read data", d, 0);
    rd(2'b11, d); chk("R11 unused fault", rd_fault, 0); chk("R11 unused data", d, 0);
    rd_en = 0; rd(2'b01, d); chk("R11 no strobe", rd_fault, 0);

    // R3 back-pressure
    @(negedge clk); iss_ready = 0; wr_valid = 1; wr_sel = 2'b00; wr_data = 64'h0000_0001_0000_0051;
    @(negedge clk);
    chk("R3 A issued", iss_vector, 8'h51); chk("R3 stall ready", wr_ready, 0);
    wr_data = 64'h0000_0002_0000_0062;
    @(negedge clk);
    chk("R3 A held", {iss_valid, iss_vector}, {1'b1, 8'h51});
    iss_ready = 1; #1 chk("R3 ready follows consumer", wr_ready, 1);
    @(negedge clk);
    chk("R3 B follows", {iss_valid, iss_vector}, {1'b1, 8'h62});
    wr_data = 64'h0000_0003_0000_0073;
    @(negedge clk); wr_valid = 0;
    chk("R3 back-to-back", {iss_valid, iss_vector}, {1'b1, 8'h73});
    @(negedge clk);
    chk("R3 drained", iss_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule